// File: doc/BRIEF.md
# Inter-Processor Command and Message Interrupt Decoder

This block turns two kinds of interrupt message into one common delivery request. The first kind comes from software writes to a pair of 32-bit command words. A write to the high word only stores a destination. A write to the low word starts a send at once, and that send uses whatever high word was stored last. The second kind is a message-signalled interrupt: an address word and a data word that arrive together with a valid strobe. The block pulls the destination, the mode fields and the vector out of that pair and does not look at the redirection hint.

Every request leaves the block as a one-cycle `req_valid` pulse, one clock after the write or message that caused it. The pulse carries the destination ID, the destination mode, the delivery mode, the vector, the trigger mode and a 2-bit destination shorthand. A downstream stage turns the destination into a set of target processors and performs the delivery. When a command send and a message arrive in the same cycle, the command goes out first and the message is parked for one cycle.

The arbiter has two states. ST_IDLE means no message is parked. ST_HOLD means one message is parked. The transitions are:
- IDLE_TO_HOLD: a command send and a message arrive together.
- HOLD_STAY_CMD: while parked, another command send arrives. The command goes out, the parked message stays, and any new message in that cycle is discarded.
- HOLD_STAY_SWAP: while parked, no command send arrives but a new message does. The parked message goes out and the new message takes its place.
- HOLD_TO_IDLE: while parked, neither a command send nor a new message arrives. The parked message goes out.

Top module: `ipi_msi_decoder`

## Requirements
- R1: After reset, `req_valid` is 0 and the stored high command word is 0. A low-word write made before any high-word write therefore reports destination 0.
- R2: A write with `cmd_wr_hi`=1 only stores the word and raises no request by itself.
- R3: A write with `cmd_wr_hi`=0 gives `req_valid`=1 on the next cycle. The fields come from that write: vector = bits 7:0, delivery mode = bits 10:8, destination mode = bit 11, trigger = bit 15, shorthand = bits 19:18.
- R4: The destination of a command send is bits 31:24 of the most recently written high word.
- R5: For a message, the destination = address bits 19:12 and the destination mode = address bit 2. Address bit 3 (the redirection hint) has no effect on any output.
- R6: For a message, the vector = data bits 7:0, the delivery mode = data bits 10:8 and the trigger = data bit 15. The shorthand output is 0.
- R7: When a command send and a message arrive in the same cycle, the command request comes out on the next cycle and the message request on the cycle after that.
- R8: While a message is parked, a further command send goes out first and the parked message stays parked. A new message that arrives in that cycle is discarded.
- R9: While a message is parked and no command send arrives, the parked message goes out on the next cycle. A new message arriving in that cycle becomes the parked message and goes out on the cycle after.
- R10: Each request lasts exactly one cycle. `req_valid` falls on the cycle after a request unless a new request is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr_en | input | 1 | Command-word write strobe |
| cmd_wr_hi | input | 1 | 1 selects the high word, 0 selects the low word (which sends) |
| cmd_wr_data | input | 32 | Command word being written |
| msi_valid | input | 1 | Message-signalled interrupt strobe |
| msi_addr | input | 32 | Message address word |
| msi_data | input | 32 | Message data word |
| req_valid | output | 1 | One-cycle request pulse |
| req_dest | output | 8 | Destination ID |
| req_dest_mode | output | 1 | Destination mode |
| req_dlv_mode | output | 3 | Delivery mode |
| req_vector | output | 8 | Interrupt vector |
| req_trigger | output | 1 | Trigger mode (1 = level) |
| req_shorthand | output | 2 | Destination shorthand (0 for messages) |

## Verification
A stale high word shows up as a wrong `req_dest` on the very next command send, one cycle after the low-word write. A wrong arbiter state shows up within two cycles of a collision. Either the parked message fails to appear on the following cycle, or it appears twice, or it appears in place of a command that should have won. A parked register that is overwritten when it should have been held shows up as wrong message fields when the parked request is finally issued. Random traffic with frequent collisions and back-to-back messages keeps the arbiter in ST_HOLD for long runs, so every transition is exercised repeatedly.

// File: rtl/ipimsg_pkg.sv
package ipimsg_pkg;
    localparam int WORD_W = 32;
    localparam int DEST_W = 8;
    localparam int VEC_W  = 8;
    localparam int DLV_W  = 3;
    localparam int SH_W   = 2;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              dmode;
        logic [DLV_W-1:0]  dlv;
        logic [VEC_W-1:0]  vec;
        logic              trig;
        logic [SH_W-1:0]   sh;
    } ireq_t;

    localparam int IREQ_W = $bits(ireq_t);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } arb_st_t;
endpackage

// File: rtl/ipi_cmd_port.sv
module ipi_cmd_port
    import ipimsg_pkg::*;
#(
    parameter int VEC_LSB  = 0,
    parameter int DLV_LSB  = 8,
    parameter int DM_BIT   = 11,
    parameter int TRIG_BIT = 15,
    parameter int SH_LSB   = 18,
    parameter int DEST_LSB = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wr_data,
    output logic              fire,
    output ireq_t             req
);
    logic [WORD_W-1:0] hi_q;

    // High word: storage only
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_q <= '0;
        else if (wr_en && wr_hi)
            hi_q <= wr_data;
    end

    // Low word: decoded immediately into a send
    always_comb begin
        fire      = wr_en && !wr_hi;
        req.dest  = hi_q[DEST_LSB +: DEST_W];
        req.dmode = wr_data[DM_BIT];
        req.dlv   = wr_data[DLV_LSB +: DLV_W];
        req.vec   = wr_data[VEC_LSB +: VEC_W];
        req.trig  = wr_data[TRIG_BIT];
        req.sh    = wr_data[SH_LSB +: SH_W];
    end

    AST_HI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_hi) |=> $stable(hi_q)) else $error("high word changed without write"); // R2
endmodule

// File: rtl/ipi_msi_port.sv
module ipi_msi_port
    import ipimsg_pkg::*;
#(
    parameter int DEST_LSB = 12,
    parameter int DM_BIT   = 2,
    parameter int VEC_LSB  = 0,
    parameter int DLV_LSB  = 8,
    parameter int TRIG_BIT = 15
) (
    input  logic [WORD_W-1:0] addr,
    input  logic [WORD_W-1:0] data,
    output ireq_t             req
);
    // Redirection hint (address bit 3) deliberately not decoded
    always_comb begin
        req.dest  = addr[DEST_LSB +: DEST_W];
        req.dmode = addr[DM_BIT];
        req.dlv   = data[DLV_LSB +: DLV_W];
        req.vec   = data[VEC_LSB +: VEC_W];
        req.trig  = data[TRIG_BIT];
        req.sh    = '0;
    end
endmodule

// File: rtl/ipi_arb_fsm.sv
module ipi_arb_fsm
    import ipimsg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cmd_fire,
    input  ireq_t cmd_req,
    input  logic  msi_valid,
    input  ireq_t msi_req,
    output logic  out_valid,
    output ireq_t out_req
);
    arb_st_t state_q, state_d;
    ireq_t   pend_q, pend_d;

    // Next state
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_fire && msi_valid) begin   // IDLE_TO_HOLD
                    state_d = ST_HOLD;
                    pend_d  = msi_req;
                end
            end
            ST_HOLD: begin
                if (cmd_fire) begin                // HOLD_STAY_CMD
                    state_d = ST_HOLD;
                end else if (msi_valid) begin      // HOLD_STAY_SWAP
                    state_d = ST_HOLD;
                    pend_d  = msi_req;
                end else begin                     // HOLD_TO_IDLE
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_req   <= '0;
        end else begin
            out_valid <= cmd_fire || msi_valid || (state_q == ST_HOLD);
            if (cmd_fire)
                out_req <= cmd_req;
            else if (state_q == ST_HOLD)
                out_req <= pend_q;
            else
                out_req <= msi_req;
        end
    end

    AST_CMD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |=> (out_valid && out_req == $past(cmd_req))) else $error("command not issued"); // R3
    AST_COLLIDE_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && msi_valid && state_q == ST_IDLE) |=> (state_q == ST_HOLD && pend_q == $past(msi_req))) else $error("collision not parked"); // R7
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && cmd_fire) |=> (state_q == ST_HOLD && $stable(pend_q))) else $error("parked message lost"); // R8
    AST_HOLD_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !cmd_fire) |=> (out_valid && out_req == $past(pend_q))) else $error("parked message not issued"); // R9
    AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_fire && !msi_valid && state_q == ST_IDLE) |=> !out_valid) else $error("spurious request"); // R10
endmodule

// File: rtl/ipi_msi_decoder.sv
module ipi_msi_decoder
    import ipimsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_en,
    input  logic              cmd_wr_hi,
    input  logic [WORD_W-1:0] cmd_wr_data,
    input  logic              msi_valid,
    input  logic [WORD_W-1:0] msi_addr,
    input  logic [WORD_W-1:0] msi_data,
    output logic              req_valid,
    output logic [DEST_W-1:0] req_dest,
    output logic              req_dest_mode,
    output logic [DLV_W-1:0]  req_dlv_mode,
    output logic [VEC_W-1:0]  req_vector,
    output logic              req_trigger,
    output logic [SH_W-1:0]   req_shorthand
);
    logic  cmd_fire;
    ireq_t cmd_req, msi_req, out_req;

    ipi_cmd_port u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_en(cmd_wr_en), .wr_hi(cmd_wr_hi),
        .wr_data(cmd_wr_data), .fire(cmd_fire), .req(cmd_req)
    );

    ipi_msi_port u_msi (
        .addr(msi_addr), .data(msi_data), .req(msi_req)
    );

    ipi_arb_fsm u_arb (
        .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .cmd_req(cmd_req),
        .msi_valid(msi_valid), .msi_req(msi_req),
        .out_valid(req_valid), .out_req(out_req)
    );

    assign req_dest      = out_req.dest;
    assign req_dest_mode = out_req.dmode;
    assign req_dlv_mode  = out_req.dlv;
    assign req_vector    = out_req.vec;
    assign req_trigger   = out_req.trig;
    assign req_shorthand = out_req.sh;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !req_valid) else $error("request after reset"); // R1
    AST_HI_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_en && cmd_wr_hi && !msi_valid && u_arb.state_q == ST_IDLE) |=> !req_valid) else $error("high write sent"); // R2
    AST_MSI_NO_SH: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_valid && !cmd_fire && u_arb.state_q == ST_IDLE) |=> (req_valid && req_shorthand == '0)) else $error("message shorthand nonzero"); // R6
endmodule

// File: tb/sim_ipi_msi_decoder.sv
module sim_ipi_msi_decoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_wr_en, cmd_wr_hi, msi_valid;
    logic [31:0] cmd_wr_data, msi_addr, msi_data;
    logic        req_valid, req_dest_mode, req_trigger;
    logic [7:0]  req_dest, req_vector;
    logic [2:0]  req_dlv_mode;
    logic [1:0]  req_shorthand;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    logic [31:0] m_hi;
    bit          m_pend;
    logic [22:0] m_pend_f;
    bit          e_valid;
    logic [22:0] e_f;
    string       e_tag;

    always #2 clk = ~clk;

    ipi_msi_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wr_hi(cmd_wr_hi),
        .cmd_wr_data(cmd_wr_data), .msi_valid(msi_valid), .msi_addr(msi_addr),
        .msi_data(msi_data), .req_valid(req_valid), .req_dest(req_dest),
        .req_dest_mode(req_dest_mode), .req_dlv_mode(req_dlv_mode),
        .req_vector(req_vector), .req_trigger(req_trigger),
        .req_shorthand(req_shorthand)
    );

    // fields packed as {dest, dmode, dlv, vec, trig, sh}
    function automatic logic [22:0] cmd_fields(logic [31:0] hi, logic [31:0] lo);
        return {hi[31:24], lo[11], lo[10:8], lo[7:0], lo[15], lo[19:18]};
    endfunction

    function automatic logic [22:0] msi_fields(logic [31:0] a, logic [31:0] d);
        return {a[19:12], a[2], d[10:8], d[7:0], d[15], 2'b00};
    endfunction

    task automatic check(string tag);
        logic [22:0] act;
        act = {req_dest, req_dest_mode, req_dlv_mode, req_vector, req_trigger, req_shorthand};
        checks++;
        if (req_valid !== e_valid || (e_valid && act !== e_f)) begin
            errors++;
            $display("FAIL %s: valid=%0b fields=%h expected valid=%0b fields=%h",
                     tag, req_valid, act, e_valid, e_f);
        end
    endtask

    // drive one cycle at a negedge, then check at the next negedge
    task automatic cyc(bit cw, bit chi, logic [31:0] cd, bit mv, logic [31:0] ma, logic [31:0] md);
        bit fire;
        cmd_wr_en = cw; cmd_wr_hi = chi; cmd_wr_data = cd;
        msi_valid = mv; msi_addr = ma; msi_data = md;
        fire = cw && !chi;
        e_valid = 1'b0;
        e_tag = chi && cw ? "R2" : "R10";
        if (fire) begin
            e_valid = 1'b1; e_f = cmd_fields(m_hi, cd);
            if (m_pend) e_tag = "R8";
            else if (mv) begin m_pend = 1'b1; m_pend_f = msi_fields(ma, md); e_tag = "R7"; end
            else e_tag = "R3";
        end else if (m_pend) begin
            e_valid = 1'b1; e_f = m_pend_f; e_tag = "R9";
            if (mv) m_pend_f = msi_fields(ma, md);
            else m_pend = 1'b0;
        end else if (mv) begin
            e_valid = 1'b1; e_f = msi_fields(ma, md); e_tag = "R5";
        end
        if (cw && chi) m_hi = cd;
        @(negedge clk);
        check(e_tag);
    endtask

    task automatic idle(string tag);
        cyc(0, 0, 0, 0, 0, 0);
        e_tag = tag;
    endtask

    initial begin
        rst_n = 1'b0;
        cmd_wr_en = 0; cmd_wr_hi = 0; cmd_wr_data = 0;
        msi_valid = 0; msi_addr = 0; msi_data = 0;
        m_hi = 0; m_pend = 0; m_pend_f = 0; e_valid = 0; e_f = 0;
        repeat (3) @(negedge clk);
        check("R1");                               // R1 quiet in reset
        rst_n = 1'b1;
        // R1: low write before any high write has destination 0
        cyc(1, 0, 32'h000C_8A5F, 0, 0, 0);
        // R2: high write alone sends nothing
        cyc(1, 1, 32'hA700_0000, 0, 0, 0);
        // R3 R4: low write uses stored destination and its own fields
        cyc(1, 0, 32'h0008_CB33, 0, 0, 0);
        idle("R10");                               // R10 pulse ends
        // R5 R6: message with redirection hint set (address bit 3)
        cyc(0, 0, 0, 1, 32'hFEE5_A00C, 32'h0000_8542);
        // R5: same message with hint cleared must match
        cyc(0, 0, 0, 1, 32'hFEE5_A004, 32'h0000_8542);
        // R7: collision, command first then message
        cyc(1, 0, 32'h0004_0221, 1, 32'hFEE3_3000, 32'h0000_0477);
        // R8: another send while parked; new message discarded
        cyc(1, 0, 32'h0000_0130, 1, 32'hFEE9_9004, 32'h0000_0699);
        // R9: parked message goes out; new one takes its place
        cyc(0, 0, 0, 1, 32'hFEE1_1000, 32'h0000_8711);
        idle("R9");
        idle("R10");
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 3000; i++) begin
            bit cw, chi, mv;
            cw  = ($urandom % 3) == 0;
            chi = ($urandom % 2) == 1;
            mv  = ($urandom % 2) == 1;
            cyc(cw, chi, $urandom, mv, $urandom, $urandom);
        end
        idle("R10");
        idle("R10");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule